// File: doc/BRIEF.md
# Reset and Interrupt Entry Sequencer

This block sits beside a processor's execution core and takes over the memory bus whenever the machine must jump to a service routine. It watches three event sources: a reset input (`res_n`), an edge-detected non-maskable request (`nmi_n`) and a level-sensitive maskable request (`irq_n`) that the interrupt-disable flag can block. When the core signals that an instruction has finished and an event is pending, the block picks the most urgent one and runs a fixed seven-cycle entry sequence. For an interrupt, the sequence saves the return address and the status byte on the stack page. For every event, it then reads a two-byte pointer from the top of memory and hands it to the core as the new program counter.

Reset does not wait for an instruction boundary. It starts on the first clock edge after `res_n` returns high. It writes nothing to the stack and leaves the stack pointer alone. The memory bus has fixed timing and no back-pressure: the block drives an address and a read or write strobe in a cycle, and the memory must return `mem_rdata` combinationally in that same cycle. The core must keep off the bus while `busy` is high. It loads `pc_new`, `sp_new` and the disable flag on the cycle they are strobed.

Top module: `vec_entry_seq`

## Requirements
- R1: While `res_n` is low, `busy`, `mem_we`, `mem_re` and `pc_load` are low. After `res_n` goes high, the reset sequence starts at the next clock edge whatever `instr_done` is, so `busy` is high one cycle after release.
- R2: A reset sequence keeps `busy` high for exactly 7 cycles. It makes no write and reads 0xFFFC then 0xFFFD. In its last cycle it asserts `pc_load` with `pc_new` = {byte at 0xFFFD, byte at 0xFFFC}, and it never asserts `sp_load`.
- R3: A non-maskable request is latched on a high-to-low change of `nmi_n` and stays pending after `nmi_n` returns high. A level that is already low when `res_n` is released is not an edge.
- R4: The maskable request is taken only if, at the starting edge, `irq_n` is low and `i_flag` is 0. While `i_flag` is 1, or after `irq_n` has returned high, it has no effect.
- R5: Interrupt service starts only at a clock edge where the block is idle and `instr_done` is 1. `busy` rises in the following cycle.
- R6: When several events are pending at a starting edge, reset wins over non-maskable, and non-maskable wins over maskable. The losing request is served by a later sequence if it is still pending.
- R7: An interrupt sequence keeps `busy` high for 7 cycles. In cycles 3, 4 and 5 it writes `ret_pc[15:8]` to 0x0100+sp, `ret_pc[7:0]` to 0x0100+(sp-1) and `status` to 0x0100+(sp-2), with the low byte wrapping inside page 1. Cycles 6 and 7 read the low and then the high vector byte. In cycle 7 it asserts `pc_load` with {high, low} and `sp_load` with `sp_new` = sp-3 (8-bit wrap).
- R8: The non-maskable vector is read from 0xFFFA/0xFFFB and the maskable vector from 0xFFFE/0xFFFF. The low byte is at the lower address.
- R9: `i_set` pulses for exactly one cycle, the last cycle of every sequence, reset included.
- R10: A latched non-maskable request is cleared when its vector read begins. `nmi_n` held low afterwards causes no further service, and a fresh high-to-low change is latched again.
- R11: `mem_we` and `mem_re` are never high together. Writes go only to page 1 (address bits 15:8 = 0x01) and reads only to 0xFFF8–0xFFFF.
- R12: `ret_pc`, `status` and `sp` are sampled at the starting edge. Changes to them during the sequence do not alter the bytes written or `sp_new`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Reset event, active low; synchronous |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active-low level |
| instr_done | input | 1 | High in the cycle where the current instruction completes |
| i_flag | input | 1 | Interrupt-disable flag from the status register |
| ret_pc | input | 16 | Return address to save |
| status | input | 8 | Status byte to save |
| sp | input | 8 | Current stack pointer (low byte) |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | Sequence in progress; the block owns the bus |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | 16 | Fetched vector |
| sp_load | output | 1 | Load `sp_new` into the stack pointer |
| sp_new | output | 8 | Stack pointer after the three pushes |
| i_set | output | 1 | Set the interrupt-disable flag |

## Verification
The hardest situations to reach are the ones where two events collide in a single cycle. One is a non-maskable edge that lands on the very edge where reset is released. The bench forces this by raising `res_n` and lowering `nmi_n` at the same falling clock edge. It then checks that reset runs first and that the latched request is served right after. The other collisions are a non-maskable request that stays low across its own service and a maskable request that is still asserted when the disable flag lifts. For those, the bench holds the inputs steady across sequence boundaries and watches whether a new sequence starts. It also changes the snapshot inputs in the middle of a sequence to show that the values pushed do not move.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_RST  = 2'd1,
    EV_NMI  = 2'd2,
    EV_IRQ  = 2'd3
  } ev_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_C1   = 3'd1,
    ST_C2   = 3'd2,
    ST_C3   = 3'd3,
    ST_C4   = 3'd4,
    ST_C5   = 3'd5,
    ST_C6   = 3'd6,
    ST_C7   = 3'd7
  } step_t;

  // low three address bits of each vector pair's first byte, top of memory
  function automatic logic [2:0] vec_low(ev_kind_t k);
    case (k)
      EV_NMI:  return 3'b010;
      EV_RST:  return 3'b100;
      default: return 3'b110;
    endcase
  endfunction

endpackage

// File: rtl/vs_evt_arb.sv
module vs_evt_arb
  import vecseq_pkg::*;
(
  input  logic     clk,
  input  logic     res_n,
  input  logic     nmi_n,
  input  logic     irq_n,
  input  logic     i_flag,
  input  logic     instr_done,
  input  logic     idle,
  input  logic     clr_nmi,
  output logic     start,
  output ev_kind_t start_kind
);

  logic nmi_q;
  logic nmi_pend;
  logic rst_pend;
  logic nmi_edge;
  logic irq_req;

  assign nmi_edge = nmi_q & ~nmi_n;
  assign irq_req  = ~irq_n & ~i_flag;

  always_ff @(posedge clk) begin
    if (!res_n) begin
      nmi_q    <= nmi_n;
      nmi_pend <= 1'b0;
      rst_pend <= 1'b1;
    end else begin
      nmi_q <= nmi_n;
      if (nmi_edge)
        nmi_pend <= 1'b1;
      else if (clr_nmi)
        nmi_pend <= 1'b0;
      if (start && start_kind == EV_RST)
        rst_pend <= 1'b0;
    end
  end

  // fixed priority: reset, then non-maskable, then maskable
  always_comb begin
    start_kind = EV_NONE;
    if (rst_pend)
      start_kind = EV_RST;
    else if (instr_done && nmi_pend)
      start_kind = EV_NMI;
    else if (instr_done && irq_req)
      start_kind = EV_IRQ;
  end

  assign start = idle && (start_kind != EV_NONE);

  // R3
  nmi_latch_edge_chk: assert property (@(posedge clk) disable iff (!res_n)
    $rose(nmi_pend) |-> (!$past(nmi_n) && $past(nmi_n, 2)));

  // R10
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!res_n)
    $fell(nmi_pend) |-> $past(clr_nmi));

endmodule

// File: rtl/vs_step_fsm.sv
module vs_step_fsm
  import vecseq_pkg::*;
(
  input  logic     clk,
  input  logic     res_n,
  input  logic     start,
  input  ev_kind_t start_kind,
  output step_t    step,
  output ev_kind_t kind,
  output logic     idle
);

  always_ff @(posedge clk) begin
    if (!res_n) begin
      step <= ST_IDLE;
      kind <= EV_NONE;
    end else if (step == ST_IDLE) begin
      if (start) begin
        step <= ST_C1;
        kind <= start_kind;
      end
    end else if (step == ST_C7) begin
      step <= ST_IDLE;
    end else begin
      step <= step_t'(step + 3'd1);
    end
  end

  assign idle = (step == ST_IDLE);

  // R5
  seq_begins_on_start_chk: assert property (@(posedge clk) disable iff (!res_n)
    (step == ST_C1) |-> $past(start));

endmodule

// File: rtl/vs_bus_mux.sv
module vs_bus_mux
  import vecseq_pkg::*;
#(
  parameter int              DW       = 8,
  parameter int              AW       = 2 * DW,
  parameter logic [DW-1:0]   STK_PAGE = DW'(1)
) (
  input  logic          clk,
  input  logic          res_n,
  input  logic          start,
  input  step_t         step,
  input  ev_kind_t      kind,
  input  logic [AW-1:0] ret_pc,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          pc_load,
  output logic [AW-1:0] pc_new,
  output logic          sp_load,
  output logic [DW-1:0] sp_new,
  output logic          i_set
);

  logic [AW-1:0] pc_s;
  logic [DW-1:0] st_s;
  logic [DW-1:0] sp_s;
  logic [DW-1:0] lo_q;
  logic [AW-1:0] vec_addr;
  logic          pushes;

  assign vec_addr = {{(AW-3){1'b1}}, vec_low(kind)};
  assign pushes   = (kind != EV_RST);

  always_ff @(posedge clk) begin
    if (!res_n) begin
      pc_s <= '0;
      st_s <= '0;
      sp_s <= '0;
      lo_q <= '0;
    end else begin
      if (start) begin
        pc_s <= ret_pc;
        st_s <= status;
        sp_s <= sp;
      end
      if (step == ST_C6)
        lo_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    pc_load   = 1'b0;
    pc_new    = '0;
    sp_load   = 1'b0;
    sp_new    = sp_s - DW'(3);
    i_set     = 1'b0;
    case (step)
      ST_C3: if (pushes) begin
        mem_we    = 1'b1;
        mem_addr  = {STK_PAGE, sp_s};
        mem_wdata = pc_s[AW-1:DW];
      end
      ST_C4: if (pushes) begin
        mem_we    = 1'b1;
        mem_addr  = {STK_PAGE, sp_s - DW'(1)};
        mem_wdata = pc_s[DW-1:0];
      end
      ST_C5: if (pushes) begin
        mem_we    = 1'b1;
        mem_addr  = {STK_PAGE, sp_s - DW'(2)};
        mem_wdata = st_s;
      end
      ST_C6: begin
        mem_re   = 1'b1;
        mem_addr = vec_addr;
      end
      ST_C7: begin
        mem_re   = 1'b1;
        mem_addr = vec_addr | AW'(1);
        pc_load  = 1'b1;
        pc_new   = {mem_rdata, lo_q};
        sp_load  = pushes;
        i_set    = 1'b1;
      end
      default: ;
    endcase
  end

  // R11
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!res_n)
    !(mem_we && mem_re));

  // R11
  write_page_chk: assert property (@(posedge clk) disable iff (!res_n)
    mem_we |-> (mem_addr[AW-1:DW] == STK_PAGE));

  // R2
  reset_no_write_chk: assert property (@(posedge clk) disable iff (!res_n)
    (kind == EV_RST) |-> (!mem_we && !sp_load));

  // R12
  push_snapshot_chk: assert property (@(posedge clk) disable iff (!res_n)
    (step == ST_C3 && mem_we) |-> (mem_wdata == $past(ret_pc[AW-1:DW], 3)));

endmodule

// File: rtl/vec_entry_seq.sv
module vec_entry_seq
  import vecseq_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] STK_PAGE = DW'(1)
) (
  input  logic            clk,
  input  logic            res_n,
  input  logic            nmi_n,
  input  logic            irq_n,
  input  logic            instr_done,
  input  logic            i_flag,
  input  logic [2*DW-1:0] ret_pc,
  input  logic [DW-1:0]   status,
  input  logic [DW-1:0]   sp,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic            busy,
  output logic            pc_load,
  output logic [2*DW-1:0] pc_new,
  output logic            sp_load,
  output logic [DW-1:0]   sp_new,
  output logic            i_set
);

  localparam int AW = 2 * DW;

  logic     start;
  ev_kind_t start_kind;
  step_t    step;
  ev_kind_t kind;
  logic     idle;
  logic     clr_nmi;

  assign clr_nmi = (step == ST_C6) && (kind == EV_NMI);
  assign busy    = ~idle;

  vs_evt_arb u_arb (
    .clk        (clk),
    .res_n      (res_n),
    .nmi_n      (nmi_n),
    .irq_n      (irq_n),
    .i_flag     (i_flag),
    .instr_done (instr_done),
    .idle       (idle),
    .clr_nmi    (clr_nmi),
    .start      (start),
    .start_kind (start_kind)
  );

  vs_step_fsm u_fsm (
    .clk        (clk),
    .res_n      (res_n),
    .start      (start),
    .start_kind (start_kind),
    .step       (step),
    .kind       (kind),
    .idle       (idle)
  );

  vs_bus_mux #(.DW(DW), .AW(AW), .STK_PAGE(STK_PAGE)) u_bus (
    .clk       (clk),
    .res_n     (res_n),
    .start     (start),
    .step      (step),
    .kind      (kind),
    .ret_pc    (ret_pc),
    .status    (status),
    .sp        (sp),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .pc_load   (pc_load),
    .pc_new    (pc_new),
    .sp_load   (sp_load),
    .sp_new    (sp_new),
    .i_set     (i_set)
  );

  // R5
  service_at_boundary_chk: assert property (@(posedge clk) disable iff (!res_n)
    ($rose(busy) && kind != EV_RST) |-> $past(instr_done));

  // R4
  irq_gated_chk: assert property (@(posedge clk) disable iff (!res_n)
    ($rose(busy) && kind == EV_IRQ) |-> (!$past(irq_n) && !$past(i_flag)));

  // R7
  seven_cycle_chk: assert property (@(posedge clk) disable iff (!res_n)
    pc_load |-> ($past(busy, 6) && !$past(busy, 7)));

  // R9
  iset_single_chk: assert property (@(posedge clk) disable iff (!res_n)
    i_set |=> !i_set);

endmodule

// File: tb/vec_entry_seq_bench.sv
module vec_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        res_n, nmi_n, irq_n, instr_done, i_flag;
  logic [15:0] ret_pc;
  logic [7:0]  status, sp, mem_rdata;
  logic [15:0] mem_addr, pc_new;
  logic [7:0]  mem_wdata, sp_new;
  logic        mem_we, mem_re, busy, pc_load, sp_load, i_set;

  logic [7:0] vtab [8];

  int nchk = 0;
  int nfail = 0;

  // capture results
  bit   seen;
  int   waited, ncyc, nwr, nrd, npc, nspl, niset;
  int   wa [3];
  int   wd [3];
  int   ra [2];
  int   got_pc, got_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb mem_rdata = (mem_addr[15:3] == 13'h1FFF) ? vtab[mem_addr[2:0]] : 8'h00;

  vec_entry_seq u_vec_entry_seq (
    .clk(clk), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n),
    .instr_done(instr_done), .i_flag(i_flag), .ret_pc(ret_pc),
    .status(status), .sp(sp), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .busy(busy), .pc_load(pc_load), .pc_new(pc_new),
    .sp_load(sp_load), .sp_new(sp_new), .i_set(i_set)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // wait up to maxw cycles for a sequence, then record it; optionally
  // scramble the snapshot inputs once the sequence is running
  task automatic grab(input int maxw, input bit scramble);
    seen = 0; waited = 0; ncyc = 0; nwr = 0; nrd = 0; npc = 0; nspl = 0; niset = 0;
    got_pc = 0; got_sp = 0;
    while (!busy && waited < maxw) begin
      @(negedge clk);
      waited++;
    end
    if (!busy) return;
    seen = 1;
    if (scramble) begin
      ret_pc = 16'hFFFF; status = 8'h00; sp = 8'h77;
    end
    while (busy) begin
      ncyc++;
      if (mem_we) begin
        if (nwr < 3) begin wa[nwr] = int'(mem_addr); wd[nwr] = int'(mem_wdata); end
        nwr++;
      end
      if (mem_re) begin
        if (nrd < 2) ra[nrd] = int'(mem_addr);
        nrd++;
      end
      if (mem_we && mem_re) check(0, "R11", "we and re together", 1, 0);
      if (pc_load) begin npc++; got_pc = int'(pc_new); end
      if (sp_load) begin nspl++; got_sp = int'(sp_new); end
      if (i_set) niset++;
      @(negedge clk);
    end
    if (niset != 0) i_flag = 1'b1;
  endtask

  task automatic t_reset();
    res_n = 0; nmi_n = 1; irq_n = 1; instr_done = 0; i_flag = 0;
    ret_pc = 16'h0; status = 8'h0; sp = 8'hFF;
    repeat (3) @(negedge clk);
    check(!busy && !mem_we && !mem_re && !pc_load, "R1", "outputs in reset",
          {busy, mem_we, mem_re, pc_load}, 0);
    res_n = 1;
    grab(4, 0);
    check(seen && waited == 1, "R1", "reset start delay", waited, 1);
    check(ncyc == 7, "R2", "reset length", ncyc, 7);
    check(nwr == 0 && nspl == 0, "R2", "reset writes/sp_load", nwr + nspl, 0);
    check(ra[0] == 'hFFFC && ra[1] == 'hFFFD, "R2", "reset read addr", ra[0], 'hFFFC);
    check(got_pc == 'hC123, "R2", "reset pc", got_pc, 'hC123);
    check(niset == 1, "R9", "i_set pulses", niset, 1);
  endtask

  task automatic t_nmi_wait();
    i_flag = 1; sp = 8'hFD; ret_pc = 16'h1234; status = 8'hA5;
    instr_done = 0; nmi_n = 0;
    repeat (3) @(negedge clk);
    check(!busy, "R5", "no start without instr_done", busy, 0);
    nmi_n = 1;
    @(negedge clk);
    instr_done = 1;
    grab(4, 0);
    instr_done = 0;
    check(seen && waited == 1, "R3", "nmi kept pending, start delay", waited, 1);
    check(ncyc == 7, "R7", "nmi length", ncyc, 7);
    check(nwr == 3 && wa[0] == 'h01FD && wd[0] == 'h12, "R7", "push hi", wd[0], 'h12);
    check(wa[1] == 'h01FC && wd[1] == 'h34, "R7", "push lo", wd[1], 'h34);
    check(wa[2] == 'h01FB && wd[2] == 'hA5, "R7", "push status", wd[2], 'hA5);
    check(ra[0] == 'hFFFA && ra[1] == 'hFFFB, "R8", "nmi vector addr", ra[0], 'hFFFA);
    check(got_pc == 'h9000, "R8", "nmi pc", got_pc, 'h9000);
    check(nspl == 1 && got_sp == 'hFA, "R7", "sp_new", got_sp, 'hFA);
    check(niset == 1, "R9", "i_set on nmi", niset, 1);
  endtask

  task automatic t_irq_snapshot();
    i_flag = 0; sp = 8'h01; ret_pc = 16'hBEEF; status = 8'h3C;
    irq_n = 0; instr_done = 1;
    grab(4, 1);
    instr_done = 0; irq_n = 1;
    check(seen, "R4", "irq served when unmasked", seen, 1);
    check(wa[0] == 'h0101 && wd[0] == 'hBE, "R12", "snapshot hi", wd[0], 'hBE);
    check(wa[1] == 'h0100 && wd[1] == 'hEF, "R12", "snapshot lo", wd[1], 'hEF);
    check(wa[2] == 'h01FF && wd[2] == 'h3C, "R7", "page wrap status", wa[2], 'h01FF);
    check(got_sp == 'hFE, "R12", "sp_new from snapshot", got_sp, 'hFE);
    check(ra[0] == 'hFFFE && got_pc == 'hA456, "R8", "irq vector", got_pc, 'hA456);
  endtask

  task automatic t_irq_masked();
    i_flag = 1; irq_n = 0; instr_done = 1;
    grab(6, 0);
    check(!seen, "R4", "masked irq ignored", seen, 0);
    i_flag = 0; instr_done = 0;
    repeat (3) @(negedge clk);
    irq_n = 1;
    @(negedge clk);
    instr_done = 1;
    grab(6, 0);
    instr_done = 0;
    check(!seen, "R4", "released irq level ignored", seen, 0);
  endtask

  task automatic t_priority_hold();
    i_flag = 0; irq_n = 0; instr_done = 0; nmi_n = 0; sp = 8'hF0;
    repeat (2) @(negedge clk);
    instr_done = 1;
    grab(4, 0);
    check(seen && ra[0] == 'hFFFA, "R6", "nmi over irq", ra[0], 'hFFFA);
    // i_flag now set by model; nmi_n still low
    grab(6, 0);
    check(!seen, "R10", "held nmi no retrigger", seen, 0);
    i_flag = 0;
    grab(4, 0);
    check(seen && ra[0] == 'hFFFE, "R6", "irq served after nmi", ra[0], 'hFFFE);
    irq_n = 1;
    nmi_n = 1;
    @(negedge clk);
    nmi_n = 0;
    grab(4, 0);
    check(seen && ra[0] == 'hFFFA, "R10", "fresh nmi edge relatched", ra[0], 'hFFFA);
    nmi_n = 1; instr_done = 0;
  endtask

  task automatic t_reset_collision();
    res_n = 0; instr_done = 1; i_flag = 0;
    nmi_n = 0;
    repeat (2) @(negedge clk);
    nmi_n = 1;
    @(negedge clk);
    res_n = 1; nmi_n = 0;
    grab(4, 0);
    check(seen && ra[0] == 'hFFFC && nwr == 0, "R6", "reset over nmi", ra[0], 'hFFFC);
    grab(4, 0);
    check(seen && ra[0] == 'hFFFA, "R3", "nmi edge at release latched", ra[0], 'hFFFA);
    // low level present through release must not count as an edge
    res_n = 0;
    repeat (2) @(negedge clk);
    res_n = 1;
    grab(4, 0);
    grab(6, 0);
    check(!seen, "R3", "low level at release not an edge", seen, 0);
    nmi_n = 1; instr_done = 0;
  endtask

  initial begin
    vtab[0] = 8'h00; vtab[1] = 8'h00;
    vtab[2] = 8'h00; vtab[3] = 8'h90;
    vtab[4] = 8'h23; vtab[5] = 8'hC1;
    vtab[6] = 8'h56; vtab[7] = 8'hA4;
    @(negedge clk);
    t_reset();
    t_nmi_wait();
    t_irq_snapshot();
    t_irq_masked();
    t_priority_hold();
    t_reset_collision();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule